// File: doc/BRIEF.md
# Frame-Synchronized Shadow Register Bank

This block holds the 8-bit control registers of a video pipeline. A serial slave, or any other simple requester, writes and reads them through an address/data port. The transfer carries a 7-bit device field, and the block answers only when that field matches its own device address. An external strap sets the low bit of that address. Each register has a shadow copy, which the bus writes and reads. It also has a working copy, which drives the datapath. The register's class decides when the working copy takes the shadow value. An immediate register takes it on the write. A frame-synchronized register takes it at the next frame-start strobe. A latent register takes it only at a frame start after software has armed a commit.

A processing-control register sits at address 0x00. Its command bits read as busy while they wait for a frame start and clear themselves once they have acted. One of them arms the latent commit. One activates a pending exposure value. One is a one-shot trigger. Read-only status inputs are mapped into the address space so that software can read them, and writes to them are dropped.

Top module: `shadow_bank`

## Requirements
- R1: After reset, address 0x00 reads 0x4A. Immediate register i reads 0x10+i, frame register i reads 0x20+i, latent register i reads 0x30+i, and the exposure register reads 0x80. Every working copy equals its shadow.
- R2: A transfer is accepted only when bus_valid is high and bus_dev equals {6'b010000, dev_sel}, that is 0x20 or 0x21. bus_ack is high in the cycle after an accepted transfer and low otherwise. Transfers to any other device field change nothing.
- R3: Immediate registers sit at 0x01..0x04. A write is visible on imm_work in the cycle after the write.
- R4: Frame registers sit at 0x10..0x13. fs_work loads the shadow values only at a frame_start cycle. A write made in the same cycle as frame_start reaches fs_work at the next frame_start.
- R5: Latent registers sit at 0x20..0x23. lat_work loads the shadow values only at a frame_start while a commit is armed.
- R6: Writing 1 to bit 7 of 0x00 arms a commit. Bit 7 reads 1 until the next frame_start. In that cycle commit_pulse is high for one cycle, and from the following cycle bit 7 reads 0.
- R7: The exposure register sits at 0x08. Writing 1 to bit 2 of 0x00 makes expo_work load the exposure shadow at the next frame_start, with expo_pulse high in that cycle. Bit 2 reads 1 until then and 0 afterwards. Without the pending bit, expo_work does not change.
- R8: Bit 1 of 0x00 is a one-shot trigger and is set at reset. While it is set, the next frame_start raises slope_pulse for that cycle and clears the bit.
- R9: A read returns the shadow value on bus_rdata in the cycle after the request. bus_rdata is 0x00 in every other cycle.
- R10: Status bytes sit at 0x40..0x43. A read returns the stat_in byte present in the request cycle, and writes to these addresses are ignored. Unmapped addresses read 0x00.
- R11: Bits 0 and 3..6 of 0x00 are plain bits. They take the written value at once and appear on proc_flags, which carries 0 in bits 7, 2 and 1. Writing 0 to a pending command bit does not cancel it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dev_sel | input | 1 | Strap that sets the low bit of the device address |
| frame_start | input | 1 | One-cycle frame-begin strobe |
| bus_valid | input | 1 | Transfer request |
| bus_write | input | 1 | 1 for a write, 0 for a read |
| bus_dev | input | 7 | Device address field of the transfer |
| bus_addr | input | 8 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_ack | output | 1 | Transfer accepted, one cycle after the request |
| bus_rdata | output | 8 | Read data, one cycle after the request |
| stat_in | input | N_STAT*8 | Live status bytes |
| proc_flags | output | 8 | Plain bits of the processing-control register |
| imm_work | output | N_IMM*8 | Working copies of the immediate registers |
| fs_work | output | N_FS*8 | Working copies of the frame registers |
| lat_work | output | N_LAT*8 | Working copies of the latent registers |
| expo_work | output | 8 | Working exposure value |
| commit_pulse | output | 1 | Latent commit taking effect |
| expo_pulse | output | 1 | Exposure change taking effect |
| slope_pulse | output | 1 | One-shot trigger firing |

## Verification
The assertions hold on every cycle. They check that the frame, latent and exposure working copies stay fixed outside their own load events. They check that commit_pulse occurs only at a frame start and that a fired command bit drops unless a new write sets it again. They also check that every acknowledge follows a request. Only the bench scenarios can show the values loaded at each event, the handling of a write that coincides with a frame edge, and read-back of the busy bits. The same holds for status reads that ignore writes and for rejection by device address, which the bench tests against a cycle model of its own.

// File: rtl/shadow_pkg.sv
package shadow_pkg;

  typedef enum logic [1:0] {
    CLS_IMMEDIATE = 2'd0,
    CLS_FRAME     = 2'd1,
    CLS_COMMIT    = 2'd2
  } slot_class_e;

  localparam logic [7:0] PROC_ADDR    = 8'h00;
  localparam logic [7:0] IMM_BASE     = 8'h01;
  localparam logic [7:0] EXPO_ADDR    = 8'h08;
  localparam logic [7:0] FS_BASE      = 8'h10;
  localparam logic [7:0] LAT_BASE     = 8'h20;
  localparam logic [7:0] STAT_BASE    = 8'h40;

  localparam logic [7:0] PROC_DEFAULT = 8'h4A;
  localparam logic [7:0] EXPO_DEFAULT = 8'h80;
  localparam logic [7:0] PLAIN_MASK   = 8'h79;

  localparam int BIT_COMMIT = 7;
  localparam int BIT_EXPO   = 2;
  localparam int BIT_SLOPE  = 1;

  localparam logic [5:0] DEV_UPPER = 6'b010000;

  function automatic logic [7:0] slot_default(slot_class_e cls, int idx);
    logic [7:0] base;
    case (cls)
      CLS_IMMEDIATE: base = 8'h10;
      CLS_FRAME:     base = 8'h20;
      default:       base = 8'h30;
    endcase
    return base + 8'(idx);
  endfunction

  function automatic logic dev_match(logic [6:0] dev, logic sel);
    return dev == {DEV_UPPER, sel};
  endfunction

  function automatic logic [7:0] slot_addr(logic [7:0] base, int idx);
    return base + 8'(idx);
  endfunction

  function automatic logic [7:0] proc_word(logic [7:0] plain, logic arm,
                                           logic expo, logic slope);
    logic [7:0] w;
    w             = plain & PLAIN_MASK;
    w[BIT_COMMIT] = arm;
    w[BIT_EXPO]   = expo;
    w[BIT_SLOPE]  = slope;
    return w;
  endfunction

endpackage

// File: rtl/sb_bus_decode.sv
module sb_bus_decode
  import shadow_pkg::*;
#(
  parameter int N_IMM = 4,
  parameter int N_FS  = 4,
  parameter int N_LAT = 4
) (
  input  logic             dev_sel,
  input  logic             bus_valid,
  input  logic             bus_write,
  input  logic [6:0]       bus_dev,
  input  logic [7:0]       bus_addr,
  output logic             dev_hit,
  output logic             wr_proc,
  output logic             wr_expo,
  output logic [N_IMM-1:0] wr_imm,
  output logic [N_FS-1:0]  wr_fs,
  output logic [N_LAT-1:0] wr_lat
);

  logic wr_any;

  assign dev_hit = dev_match(bus_dev, dev_sel);
  assign wr_any  = bus_valid & bus_write & dev_hit;
  assign wr_proc = wr_any && (bus_addr == PROC_ADDR);
  assign wr_expo = wr_any && (bus_addr == EXPO_ADDR);

  for (genvar i = 0; i < N_IMM; i++) begin : g_imm
    assign wr_imm[i] = wr_any && (bus_addr == slot_addr(IMM_BASE, i));
  end
  for (genvar i = 0; i < N_FS; i++) begin : g_fs
    assign wr_fs[i] = wr_any && (bus_addr == slot_addr(FS_BASE, i));
  end
  for (genvar i = 0; i < N_LAT; i++) begin : g_lat
    assign wr_lat[i] = wr_any && (bus_addr == slot_addr(LAT_BASE, i));
  end

endmodule

// File: rtl/sb_cmd_ctrl.sv
module sb_cmd_ctrl
  import shadow_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       frame_start,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  output logic [7:0] proc_rd,
  output logic [7:0] plain_q,
  output logic       arm_q,
  output logic       expo_q,
  output logic       slope_q,
  output logic       commit_fire,
  output logic       expo_fire,
  output logic       slope_fire
);

  assign commit_fire = frame_start & arm_q;
  assign expo_fire   = frame_start & expo_q;
  assign slope_fire  = frame_start & slope_q;

  // a command bit clears when it fires; a fresh 1 written in the same cycle re-arms it
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      plain_q <= PROC_DEFAULT & PLAIN_MASK;
      arm_q   <= PROC_DEFAULT[BIT_COMMIT];
      expo_q  <= PROC_DEFAULT[BIT_EXPO];
      slope_q <= PROC_DEFAULT[BIT_SLOPE];
    end else begin
      if (wr_en) plain_q <= wdata & PLAIN_MASK;
      arm_q   <= (arm_q   & ~commit_fire) | (wr_en & wdata[BIT_COMMIT]);
      expo_q  <= (expo_q  & ~expo_fire)   | (wr_en & wdata[BIT_EXPO]);
      slope_q <= (slope_q & ~slope_fire)  | (wr_en & wdata[BIT_SLOPE]);
    end
  end

  assign proc_rd = proc_word(plain_q, arm_q, expo_q, slope_q);

endmodule

// File: rtl/sb_slot.sv
module sb_slot
  import shadow_pkg::*;
#(
  parameter slot_class_e CLS  = CLS_IMMEDIATE,
  parameter logic [7:0]  INIT = 8'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wdata,
  input  logic       load_en,
  output logic [7:0] shadow_q,
  output logic [7:0] work_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     shadow_q <= INIT;
    else if (wr_en) shadow_q <= wdata;
  end

  if (CLS == CLS_IMMEDIATE) begin : g_direct
    logic unused_load;
    assign unused_load = load_en;
    assign work_q      = shadow_q;
  end else begin : g_held
    logic [7:0] held_q;
    // loads the pre-edge shadow; a write in the load cycle waits for the next event
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       held_q <= INIT;
      else if (load_en) held_q <= shadow_q;
    end
    assign work_q = held_q;
  end

endmodule

// File: rtl/sb_read_mux.sv
module sb_read_mux
  import shadow_pkg::*;
#(
  parameter int N_IMM  = 4,
  parameter int N_FS   = 4,
  parameter int N_LAT  = 4,
  parameter int N_STAT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_req,
  input  logic              rd_req,
  input  logic [7:0]        bus_addr,
  input  logic [7:0]        proc_rd,
  input  logic [7:0]        expo_sh,
  input  logic [N_IMM*8-1:0]  imm_sh,
  input  logic [N_FS*8-1:0]   fs_sh,
  input  logic [N_LAT*8-1:0]  lat_sh,
  input  logic [N_STAT*8-1:0] stat_in,
  output logic              bus_ack,
  output logic [7:0]        bus_rdata
);

  logic [7:0] sel_val;

  always_comb begin
    sel_val = 8'h00;
    if (bus_addr == PROC_ADDR) sel_val = proc_rd;
    if (bus_addr == EXPO_ADDR) sel_val = expo_sh;
    for (int i = 0; i < N_IMM; i++)
      if (bus_addr == slot_addr(IMM_BASE, i)) sel_val = imm_sh[i*8 +: 8];
    for (int i = 0; i < N_FS; i++)
      if (bus_addr == slot_addr(FS_BASE, i)) sel_val = fs_sh[i*8 +: 8];
    for (int i = 0; i < N_LAT; i++)
      if (bus_addr == slot_addr(LAT_BASE, i)) sel_val = lat_sh[i*8 +: 8];
    for (int i = 0; i < N_STAT; i++)
      if (bus_addr == slot_addr(STAT_BASE, i)) sel_val = stat_in[i*8 +: 8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_ack   <= 1'b0;
      bus_rdata <= 8'h00;
    end else begin
      bus_ack   <= acc_req;
      bus_rdata <= rd_req ? sel_val : 8'h00;
    end
  end

endmodule

// File: rtl/shadow_bank.sv
module shadow_bank
  import shadow_pkg::*;
#(
  parameter int N_IMM  = 4,
  parameter int N_FS   = 4,
  parameter int N_LAT  = 4,
  parameter int N_STAT = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dev_sel,
  input  logic                frame_start,
  input  logic                bus_valid,
  input  logic                bus_write,
  input  logic [6:0]          bus_dev,
  input  logic [7:0]          bus_addr,
  input  logic [7:0]          bus_wdata,
  output logic                bus_ack,
  output logic [7:0]          bus_rdata,
  input  logic [N_STAT*8-1:0] stat_in,
  output logic [7:0]          proc_flags,
  output logic [N_IMM*8-1:0]  imm_work,
  output logic [N_FS*8-1:0]   fs_work,
  output logic [N_LAT*8-1:0]  lat_work,
  output logic [7:0]          expo_work,
  output logic                commit_pulse,
  output logic                expo_pulse,
  output logic                slope_pulse
);

  localparam int IMM_W = N_IMM * 8;
  localparam int FS_W  = N_FS * 8;
  localparam int LAT_W = N_LAT * 8;

  logic             dev_hit, wr_proc, wr_expo;
  logic [N_IMM-1:0] wr_imm;
  logic [N_FS-1:0]  wr_fs;
  logic [N_LAT-1:0] wr_lat;
  logic             acc_req, rd_req;
  logic [7:0]       proc_rd, plain_q, expo_sh;
  logic             arm_q, expo_q, slope_q;
  logic             commit_fire, expo_fire, slope_fire;
  logic [IMM_W-1:0] imm_sh;
  logic [FS_W-1:0]  fs_sh;
  logic [LAT_W-1:0] lat_sh;

  sb_bus_decode #(.N_IMM(N_IMM), .N_FS(N_FS), .N_LAT(N_LAT)) u_dec (
    .dev_sel  (dev_sel),
    .bus_valid(bus_valid),
    .bus_write(bus_write),
    .bus_dev  (bus_dev),
    .bus_addr (bus_addr),
    .dev_hit  (dev_hit),
    .wr_proc  (wr_proc),
    .wr_expo  (wr_expo),
    .wr_imm   (wr_imm),
    .wr_fs    (wr_fs),
    .wr_lat   (wr_lat)
  );

  assign acc_req = bus_valid & dev_hit;
  assign rd_req  = acc_req & ~bus_write;

  sb_cmd_ctrl u_cmd (
    .clk        (clk),
    .rst_n      (rst_n),
    .frame_start(frame_start),
    .wr_en      (wr_proc),
    .wdata      (bus_wdata),
    .proc_rd    (proc_rd),
    .plain_q    (plain_q),
    .arm_q      (arm_q),
    .expo_q     (expo_q),
    .slope_q    (slope_q),
    .commit_fire(commit_fire),
    .expo_fire  (expo_fire),
    .slope_fire (slope_fire)
  );

  for (genvar i = 0; i < N_IMM; i++) begin : g_imm
    sb_slot #(.CLS(CLS_IMMEDIATE), .INIT(slot_default(CLS_IMMEDIATE, i))) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_imm[i]), .wdata(bus_wdata),
      .load_en(1'b0), .shadow_q(imm_sh[i*8 +: 8]), .work_q(imm_work[i*8 +: 8])
    );
  end

  for (genvar i = 0; i < N_FS; i++) begin : g_fs
    sb_slot #(.CLS(CLS_FRAME), .INIT(slot_default(CLS_FRAME, i))) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_fs[i]), .wdata(bus_wdata),
      .load_en(frame_start), .shadow_q(fs_sh[i*8 +: 8]), .work_q(fs_work[i*8 +: 8])
    );
  end

  for (genvar i = 0; i < N_LAT; i++) begin : g_lat
    sb_slot #(.CLS(CLS_COMMIT), .INIT(slot_default(CLS_COMMIT, i))) u_slot (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_lat[i]), .wdata(bus_wdata),
      .load_en(commit_fire), .shadow_q(lat_sh[i*8 +: 8]), .work_q(lat_work[i*8 +: 8])
    );
  end

  sb_slot #(.CLS(CLS_COMMIT), .INIT(EXPO_DEFAULT)) u_expo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_expo), .wdata(bus_wdata),
    .load_en(expo_fire), .shadow_q(expo_sh), .work_q(expo_work)
  );

  sb_read_mux #(.N_IMM(N_IMM), .N_FS(N_FS), .N_LAT(N_LAT), .N_STAT(N_STAT)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .acc_req  (acc_req),
    .rd_req   (rd_req),
    .bus_addr (bus_addr),
    .proc_rd  (proc_rd),
    .expo_sh  (expo_sh),
    .imm_sh   (imm_sh),
    .fs_sh    (fs_sh),
    .lat_sh   (lat_sh),
    .stat_in  (stat_in),
    .bus_ack  (bus_ack),
    .bus_rdata(bus_rdata)
  );

  assign proc_flags   = plain_q;
  assign commit_pulse = commit_fire;
  assign expo_pulse   = expo_fire;
  assign slope_pulse  = slope_fire;

endmodule

// File: rtl/shadow_bank_chk.sv
module shadow_bank_chk #(
  parameter int N_FS  = 4,
  parameter int N_LAT = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frame_start,
  input logic              bus_valid,
  input logic              bus_ack,
  input logic              wr_proc,
  input logic [7:0]        bus_wdata,
  input logic              commit_pulse,
  input logic              expo_pulse,
  input logic              slope_pulse,
  input logic              arm_q,
  input logic              slope_q,
  input logic [N_FS*8-1:0]  fs_work,
  input logic [N_LAT*8-1:0] lat_work,
  input logic [7:0]        expo_work
);

  // R2
  ack_after_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ack |-> $past(bus_valid));

  // R4
  frame_copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(fs_work));

  // R5
  latent_copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_pulse |=> $stable(lat_work));

  // R6
  commit_at_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_pulse |-> frame_start);

  // R6
  commit_self_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (commit_pulse && !(wr_proc && bus_wdata[7])) |=> !arm_q);

  // R7
  expo_copy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !expo_pulse |=> $stable(expo_work));

  // R8
  slope_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (slope_pulse && !(wr_proc && bus_wdata[1])) |=> !slope_q);

endmodule

bind shadow_bank shadow_bank_chk #(.N_FS(N_FS), .N_LAT(N_LAT)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_start (frame_start),
  .bus_valid   (bus_valid),
  .bus_ack     (bus_ack),
  .wr_proc     (wr_proc),
  .bus_wdata   (bus_wdata),
  .commit_pulse(commit_pulse),
  .expo_pulse  (expo_pulse),
  .slope_pulse (slope_pulse),
  .arm_q       (arm_q),
  .slope_q     (slope_q),
  .fs_work     (fs_work),
  .lat_work    (lat_work),
  .expo_work   (expo_work)
);

// File: tb/tb_shadow_bank.sv
module tb_shadow_bank;

  localparam int CLK_PERIOD = 10;
  localparam int NR = 4;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         dev_sel = 1'b0;
  logic         frame_start = 1'b0;
  logic         bus_valid = 1'b0;
  logic         bus_write = 1'b0;
  logic [6:0]   bus_dev = 7'h00;
  logic [7:0]   bus_addr = 8'h00;
  logic [7:0]   bus_wdata = 8'h00;
  logic         bus_ack;
  logic [7:0]   bus_rdata;
  logic [31:0]  stat_in = 32'h0;
  logic [7:0]   proc_flags;
  logic [31:0]  imm_work, fs_work, lat_work;
  logic [7:0]   expo_work;
  logic         commit_pulse, expo_pulse, slope_pulse;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_bank dut (
    .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .frame_start(frame_start),
    .bus_valid(bus_valid), .bus_write(bus_write), .bus_dev(bus_dev),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
    .bus_rdata(bus_rdata), .stat_in(stat_in), .proc_flags(proc_flags),
    .imm_work(imm_work), .fs_work(fs_work), .lat_work(lat_work),
    .expo_work(expo_work), .commit_pulse(commit_pulse),
    .expo_pulse(expo_pulse), .slope_pulse(slope_pulse)
  );

  // bench model
  logic [7:0] m_imm [NR];
  logic [7:0] m_fs_s [NR];
  logic [7:0] m_fs_w [NR];
  logic [7:0] m_lat_s [NR];
  logic [7:0] m_lat_w [NR];
  logic [7:0] m_exp_s, m_exp_w, m_plain;
  logic       m_arm, m_expo, m_slope;
  logic       m_ack;
  logic [7:0] m_rdata;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] pack4(input logic [7:0] a [NR]);
    return {a[3], a[2], a[1], a[0]};
  endfunction

  function automatic logic [7:0] model_read(input logic [7:0] a);
    logic [7:0] r;
    r = 8'h00;
    if (a == 8'h00) begin
      r = m_plain;
      r[7] = m_arm; r[2] = m_expo; r[1] = m_slope;
    end else if (a == 8'h08) r = m_exp_s;
    else if (a >= 8'h01 && a <= 8'h04) r = m_imm[a - 8'h01];
    else if (a >= 8'h10 && a <= 8'h13) r = m_fs_s[a - 8'h10];
    else if (a >= 8'h20 && a <= 8'h23) r = m_lat_s[a - 8'h20];
    else if (a >= 8'h40 && a <= 8'h43) r = stat_in[(a - 8'h40)*8 +: 8];
    return r;
  endfunction

  function automatic string read_req(input logic [7:0] a);
    if (a == 8'h00) return "R6";
    if ((a >= 8'h40 && a <= 8'h43) || model_read(a) == 8'h00) return "R10";
    return "R9";
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NR; i++) begin
      m_imm[i] = 8'h10 + 8'(i);
      m_fs_s[i] = 8'h20 + 8'(i); m_fs_w[i] = 8'h20 + 8'(i);
      m_lat_s[i] = 8'h30 + 8'(i); m_lat_w[i] = 8'h30 + 8'(i);
    end
    m_exp_s = 8'h80; m_exp_w = 8'h80; m_plain = 8'h48;
    m_arm = 1'b0; m_expo = 1'b0; m_slope = 1'b1;
    m_ack = 1'b0; m_rdata = 8'h00;
  endtask

  task automatic compare_state(input string tag);
    chk({"R3 imm_work ", tag}, imm_work, pack4(m_imm));
    chk({"R4 fs_work ", tag}, fs_work, pack4(m_fs_w));
    chk({"R5 lat_work ", tag}, lat_work, pack4(m_lat_w));
    chk({"R7 expo_work ", tag}, {24'h0, expo_work}, {24'h0, m_exp_w});
    chk({"R11 proc_flags ", tag}, {24'h0, proc_flags}, {24'h0, m_plain});
    chk({"R2 bus_ack ", tag}, {31'h0, bus_ack}, {31'h0, m_ack});
  endtask

  // one transfer cycle: starts and ends at a falling edge
  task automatic step(input logic fs, input logic v, input logic w,
                      input logic [6:0] dv, input logic [7:0] a, input logic [7:0] d);
    logic ok, cf, ef, sf, wr0;
    logic [7:0] rd_exp;
    frame_start = fs; bus_valid = v; bus_write = w;
    bus_dev = dv; bus_addr = a; bus_wdata = d;
    #1;
    ok = v && (dv == {6'b010000, dev_sel});
    cf = fs & m_arm; ef = fs & m_expo; sf = fs & m_slope;
    chk("R6 commit_pulse", {31'h0, commit_pulse}, {31'h0, cf});
    chk("R7 expo_pulse", {31'h0, expo_pulse}, {31'h0, ef});
    chk("R8 slope_pulse", {31'h0, slope_pulse}, {31'h0, sf});
    rd_exp = (ok && !w) ? model_read(a) : 8'h00;
    wr0 = ok && w && (a == 8'h00);
    // next-state of the model, from pre-edge values
    if (fs) for (int i = 0; i < NR; i++) m_fs_w[i] = m_fs_s[i];
    if (cf) for (int i = 0; i < NR; i++) m_lat_w[i] = m_lat_s[i];
    if (ef) m_exp_w = m_exp_s;
    m_arm   = (m_arm & ~cf)   | (wr0 & d[7]);
    m_expo  = (m_expo & ~ef)  | (wr0 & d[2]);
    m_slope = (m_slope & ~sf) | (wr0 & d[1]);
    if (ok && w) begin
      if (a == 8'h00) m_plain = d & 8'h79;
      else if (a == 8'h08) m_exp_s = d;
      else if (a >= 8'h01 && a <= 8'h04) m_imm[a - 8'h01] = d;
      else if (a >= 8'h10 && a <= 8'h13) m_fs_s[a - 8'h10] = d;
      else if (a >= 8'h20 && a <= 8'h23) m_lat_s[a - 8'h20] = d;
    end
    m_ack = ok;
    @(posedge clk);
    @(negedge clk);
    compare_state("");
    chk({read_req(a), " bus_rdata"}, {24'h0, bus_rdata}, {24'h0, rd_exp});
    frame_start = 1'b0; bus_valid = 1'b0;
  endtask

  task automatic wr(input logic fs, input logic [7:0] a, input logic [7:0] d);
    step(fs, 1'b1, 1'b1, {6'b010000, dev_sel}, a, d);
  endtask

  task automatic rd(input logic fs, input logic [7:0] a);
    step(fs, 1'b1, 1'b0, {6'b010000, dev_sel}, a, 8'h00);
  endtask

  task automatic idle(input logic fs);
    step(fs, 1'b0, 1'b0, 7'h00, 8'h00, 8'h00);
  endtask

  function automatic logic [7:0] pick_addr(input int r);
    case (r % 16)
      0:  return 8'h00;
      1:  return 8'h08;
      2, 3: return 8'h01 + 8'($urandom % 4);
      4, 5, 6: return 8'h10 + 8'($urandom % 4);
      7, 8, 9: return 8'h20 + 8'($urandom % 4);
      10, 11: return 8'h40 + 8'($urandom % 4);
      12: return 8'($urandom);
      default: return 8'h10 + 8'h10 * 8'($urandom % 2) + 8'($urandom % 4);
    endcase
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0515);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset values seen on outputs and by read-back
    chk("R1 imm_work reset", imm_work, 32'h13121110);
    chk("R1 fs_work reset", fs_work, 32'h23222120);
    chk("R1 lat_work reset", lat_work, 32'h33323130);
    chk("R1 expo_work reset", {24'h0, expo_work}, 32'h80);
    rd(1'b0, 8'h00);
    chk("R1 proc read reset", {24'h0, bus_rdata}, 32'h4A);

    // R3 immediate write
    wr(1'b0, 8'h03, 8'hA5);
    chk("R3 imm slot 2 direct", {24'h0, imm_work[23:16]}, 32'hA5);

    // R4 plain write waits, write during frame edge waits another frame
    wr(1'b0, 8'h10, 8'h11);
    chk("R4 fs slot 0 held", {24'h0, fs_work[7:0]}, 32'h20);
    idle(1'b1);
    chk("R4 fs slot 0 loaded", {24'h0, fs_work[7:0]}, 32'h11);
    wr(1'b1, 8'h11, 8'h22);
    chk("R4 edge write deferred", {24'h0, fs_work[15:8]}, 32'h21);
    idle(1'b1);
    chk("R4 edge write landed", {24'h0, fs_work[15:8]}, 32'h22);

    // R5/R6 latent write, commit, busy read-back
    wr(1'b0, 8'h22, 8'h5C);
    idle(1'b1);
    chk("R5 latent held without commit", {24'h0, lat_work[23:16]}, 32'h32);
    wr(1'b0, 8'h00, 8'h80);
    rd(1'b0, 8'h00);
    chk("R6 busy bit reads 1", {31'h0, bus_rdata[7]}, 32'h1);
    wr(1'b0, 8'h00, 8'h00);
    chk("R11 zero does not cancel commit", {31'h0, m_arm}, 32'h1);
    idle(1'b1);
    chk("R5 latent loaded at commit", {24'h0, lat_work[23:16]}, 32'h5C);
    rd(1'b0, 8'h00);
    chk("R6 busy bit cleared", {31'h0, bus_rdata[7]}, 32'h0);

    // R7 exposure activation
    wr(1'b0, 8'h08, 8'h3C);
    idle(1'b1);
    chk("R7 exposure held", {24'h0, expo_work}, 32'h80);
    wr(1'b0, 8'h00, 8'h04);
    idle(1'b1);
    chk("R7 exposure applied", {24'h0, expo_work}, 32'h3C);

    // R8 one-shot
    wr(1'b0, 8'h00, 8'h02);
    idle(1'b1);
    idle(1'b1);

    // R10 status write ignored, R2 wrong device ignored
    stat_in = 32'hCAFE_F00D;
    wr(1'b0, 8'h41, 8'h00);
    rd(1'b0, 8'h41);
    chk("R10 status read live", {24'h0, bus_rdata}, 32'hF0);
    step(1'b0, 1'b1, 1'b1, 7'h22, 8'h01, 8'h77);
    chk("R2 foreign device no write", {24'h0, imm_work[7:0]}, 32'h10);
    rd(1'b0, 8'h7E);
    chk("R10 unmapped reads zero", {24'h0, bus_rdata}, 32'h00);

    // random traffic, strap changes halfway
    for (int n = 0; n < 3000; n++) begin
      logic fs, w, good;
      logic [7:0] a;
      if (n == 1500) dev_sel = 1'b1;
      if (($urandom % 8) == 0) stat_in = $urandom;
      fs = (($urandom % 6) == 0);
      w = (($urandom % 10) < 6);
      good = (($urandom % 10) != 0);
      a = pick_addr(int'($urandom % 16));
      step(fs, ($urandom % 5) != 0, w,
           good ? {6'b010000, dev_sel} : {6'b010000, ~dev_sel}, a, 8'($urandom));
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule